// File: doc/BRIEF.md
# Video Sync-Word Filter and Detector

This block sits at the front of a serial video transmit path. Every clock it registers one 10-bit video character together with a filter-enable bit and a mode bit. It then looks for the reserved timing-reference values: the low range 000 to 003 and the high range 3FC to 3FF, in hex. A character is one of these values exactly when its upper eight bits are all zeros or all ones.

With the active-low filter enable asserted, the block rewrites such characters to their full 10-bit form: 000 for the low range and 3FF for the high range. This lets a stream that came from 8-bit equipment still carry a proper 30-bit sync preamble. All other characters, and every character while the filter is off, pass to the scrambler stage unchanged.

An active-low flag marks sync characters. It is driven by a three-state machine:

- `DET_CLEAR` means no sync character was seen; the flag is high.
- `DET_ZERO_RUN` means the last registered character had all-zero upper bits; the flag is low.
- `DET_ONE_RUN` means the last registered character had all-one upper bits; the flag is low.

Every clock the machine moves from any state to one of three targets, using the character in the input register:

- `GO_ZERO` leads to `DET_ZERO_RUN` when the upper bits are zero in video mode.
- `GO_ONE` leads to `DET_ONE_RUN` when the upper bits are all ones in video mode.
- `GO_CLEAR` leads to `DET_CLEAR` in every other case, including transport mode.

When the mode bit selects transport mode, filtering is suppressed and the flag stays high.

Top module: `sync_word_screen`

## Requirements
- R1: While reset is asserted, `sync_flag_n` is 1 and `char_out` is 000.
- R2: With `filt_en_n`=0 and `xport_mode`=0, a character from 000 to 003 appears on `char_out` as 000.
- R3: With `filt_en_n`=0 and `xport_mode`=0, a character from 3FC to 3FF appears on `char_out` as 3FF.
- R4: With `filt_en_n`=1, every character appears on `char_out` unchanged.
- R5: With `xport_mode`=1, every character appears on `char_out` unchanged, whatever `filt_en_n` is.
- R6: A character whose upper eight bits (bits 9:2) are neither all zeros nor all ones passes unchanged, whatever `filt_en_n` is.
- R7: A character registered in video mode with bits 9:2 all zeros or all ones drives `sync_flag_n` to 0. The flag changes one clock edge after the character appears on `char_out`, whatever `filt_en_n` is.
- R8: `sync_flag_n` returns to 1 one edge after a non-sync character is registered, and stays low across back-to-back sync characters.
- R9: A character registered with `xport_mode`=1 makes `sync_flag_n` 1 one edge later, even when it is a sync value.
- R10: `char_out` reflects the inputs sampled at the most recent clock edge. The edge that captures a character puts it on `char_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_in | input | 10 | Video character to be registered |
| filt_en_n | input | 1 | Active-low sync-widening filter enable |
| xport_mode | input | 1 | 1 selects transport mode, 0 selects video mode |
| char_out | output | 10 | Registered and optionally filtered character |
| sync_flag_n | output | 1 | Active-low sync character flag |

## Verification
A detector state machine stuck in the wrong state shows on `sync_flag_n` one edge after the character that should have moved it. A stale input register shows on `char_out` on the very edge that should have captured a new value. The scoreboard compares both outputs on every edge against a model built from the requirements. It feeds the two sync ranges, values next to them such as 004 and 3FB, back-to-back sync runs, and transport-mode sync values, so that a wrong transition or a lost mode bit appears within two edges.

// File: rtl/swsd_pkg.sv
package swsd_pkg;

    // Detector states: no sync seen, zero-range sync seen, one-range sync seen.
    typedef enum logic [1:0] {
        DET_CLEAR    = 2'd0,
        DET_ZERO_RUN = 2'd1,
        DET_ONE_RUN  = 2'd2
    } det_state_e;

    // Classification of the upper bits of a character.
    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_ZEROS = 2'd1,
        CLS_ONES  = 2'd2
    } hi_class_e;

endpackage

// File: rtl/swsd_capture.sv
module swsd_capture #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] char_d,
    input  logic              filt_en_n_d,
    input  logic              xport_d,
    output logic [DATA_W-1:0] char_q,
    output logic              filt_en_n_q,
    output logic              xport_q
);

    // The reset state has the filter off and video mode selected.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_q      <= '0;
            filt_en_n_q <= 1'b1;
            xport_q     <= 1'b0;
        end else begin
            char_q      <= char_d;
            filt_en_n_q <= filt_en_n_d;
            xport_q     <= xport_d;
        end
    end

endmodule

// File: rtl/swsd_filter.sv
module swsd_filter #(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic [DATA_W-1:0] char_q,
    input  logic              filt_en_n_q,
    input  logic              xport_q,
    output logic [DATA_W-1:0] char_f
);
    import swsd_pkg::*;

    localparam int HI_W = DATA_W - LOW_W;

    logic [HI_W-1:0] hi_bits;
    hi_class_e       cls;
    logic            force_low;
    logic            fill_val;

    assign hi_bits = char_q[DATA_W-1:LOW_W];

    always_comb begin
        if (hi_bits == '0)      cls = CLS_ZEROS;
        else if (hi_bits == '1) cls = CLS_ONES;
        else                    cls = CLS_PLAIN;
    end

    // Widening applies only in video mode with the filter enabled.
    assign force_low = !filt_en_n_q && !xport_q && (cls != CLS_PLAIN);
    assign fill_val  = (cls == CLS_ONES);

    assign char_f[DATA_W-1:LOW_W] = hi_bits;

    for (genvar i = 0; i < LOW_W; i++) begin : g_low
        assign char_f[i] = force_low ? fill_val : char_q[i];
    end

endmodule

// File: rtl/swsd_detect.sv
module swsd_detect #(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] char_q,
    input  logic              xport_q,
    output logic              sync_flag_n
);
    import swsd_pkg::*;

    localparam int HI_W = DATA_W - LOW_W;

    det_state_e      state_q;
    det_state_e      state_d;
    logic [HI_W-1:0] hi_bits;
    logic            hi_zero;
    logic            hi_one;

    assign hi_bits = char_q[DATA_W-1:LOW_W];
    assign hi_zero = ~|hi_bits;
    assign hi_one  = &hi_bits;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_CLEAR;
        else        state_q <= state_d;
    end

    // Next state: GO_ZERO, GO_ONE or GO_CLEAR from any state
    always_comb begin
        state_d = DET_CLEAR;
        unique case (state_q)
            DET_CLEAR, DET_ZERO_RUN, DET_ONE_RUN: begin
                if (xport_q)      state_d = DET_CLEAR;
                else if (hi_zero) state_d = DET_ZERO_RUN;
                else if (hi_one)  state_d = DET_ONE_RUN;
                else              state_d = DET_CLEAR;
            end
            default: state_d = DET_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        sync_flag_n = 1'b1;
        unique case (state_q)
            DET_CLEAR:    sync_flag_n = 1'b1;
            DET_ZERO_RUN: sync_flag_n = 1'b0;
            DET_ONE_RUN:  sync_flag_n = 1'b0;
            default:      sync_flag_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/sync_word_screen.sv
module sync_word_screen #(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] char_in,
    input  logic              filt_en_n,
    input  logic              xport_mode,
    output logic [DATA_W-1:0] char_out,
    output logic              sync_flag_n
);

    logic [DATA_W-1:0] char_q;
    logic              filt_en_n_q;
    logic              xport_q;

    swsd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_d      (char_in),
        .filt_en_n_d (filt_en_n),
        .xport_d     (xport_mode),
        .char_q      (char_q),
        .filt_en_n_q (filt_en_n_q),
        .xport_q     (xport_q)
    );

    swsd_filter #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_filter (
        .char_q      (char_q),
        .filt_en_n_q (filt_en_n_q),
        .xport_q     (xport_q),
        .char_f      (char_out)
    );

    swsd_detect #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_q      (char_q),
        .xport_q     (xport_q),
        .sync_flag_n (sync_flag_n)
    );

endmodule

// File: rtl/swsd_checker.sv
module swsd_checker #(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] char_in,
    input logic              filt_en_n,
    input logic              xport_mode,
    input logic [DATA_W-1:0] char_out,
    input logic              sync_flag_n
);

    // Edges seen since reset, saturating at 2.
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (sync_flag_n && char_out == '0));

    p_low_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !$past(filt_en_n) && !$past(xport_mode)
         && $past(char_in[DATA_W-1:LOW_W]) == '0) |-> char_out == '0);

    p_high_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !$past(filt_en_n) && !$past(xport_mode)
         && $past(char_in[DATA_W-1:LOW_W]) == '1) |-> char_out == '1);

    p_filter_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $past(filt_en_n)) |-> char_out == $past(char_in));

    p_transport_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $past(xport_mode)) |-> char_out == $past(char_in));

    p_flag_video_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && !$past(xport_mode, 2)) |->
        (sync_flag_n == !($past(char_in[DATA_W-1:LOW_W], 2) == '0 ||
                          $past(char_in[DATA_W-1:LOW_W], 2) == '1)));

    p_flag_transport_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(xport_mode, 2)) |-> sync_flag_n);

endmodule

bind sync_word_screen swsd_checker #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_in     (char_in),
    .filt_en_n   (filt_en_n),
    .xport_mode  (xport_mode),
    .char_out    (char_out),
    .sync_flag_n (sync_flag_n)
);

// File: tb/sync_word_screen_test.sv
module sync_word_screen_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] char_in = '0;
    logic       filt_en_n = 1'b1;
    logic       xport_mode = 1'b0;
    logic [9:0] char_out;
    logic       sync_flag_n;

    typedef struct {
        logic [9:0] exp_char;
        logic       exp_flag;
        string      tag;
    } item_t;

    item_t exp_q[$];
    item_t pend;
    bit    pend_valid = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;

    sync_word_screen uut (
        .clk(clk), .rst_n(rst_n), .char_in(char_in), .filt_en_n(filt_en_n),
        .xport_mode(xport_mode), .char_out(char_out), .sync_flag_n(sync_flag_n)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one character and pushes its expected results.
    task automatic drive(input logic [9:0] c, input logic fe_n, input logic xp, input string tag);
        item_t it;
        logic  hz, ho;
        @(negedge clk);
        char_in = c; filt_en_n = fe_n; xport_mode = xp;
        hz = (c[9:2] == 8'h00);
        ho = (c[9:2] == 8'hFF);
        if (!xp && !fe_n && hz)      it.exp_char = 10'h000;
        else if (!xp && !fe_n && ho) it.exp_char = 10'h3FF;
        else                         it.exp_char = c;
        it.exp_flag = !(!xp && (hz || ho));
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: char_out at the capture edge, flag one edge later.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (pend_valid) begin
                    check({pend.tag, " flag R7"}, {9'd0, sync_flag_n}, {9'd0, pend.exp_flag});
                    pend_valid = 0;
                end
                if (exp_q.size() > 0) begin
                    pend = exp_q.pop_front();
                    check({pend.tag, " char R10"}, char_out, pend.exp_char);
                    pend_valid = 1;
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 4000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 flag", {9'd0, sync_flag_n}, 10'd1);
        check("R1 char", char_out, 10'h000);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 low range widening
        drive(10'h001, 0, 0, "R2");
        drive(10'h002, 0, 0, "R2");
        drive(10'h003, 0, 0, "R2");
        drive(10'h000, 0, 0, "R2");
        // R8 leaving sync
        drive(10'h155, 0, 0, "R8");
        // R3 high range widening
        drive(10'h3FC, 0, 0, "R3");
        drive(10'h3FE, 0, 0, "R3");
        drive(10'h3FD, 0, 0, "R3");
        // R6 neighbours of the sync ranges
        drive(10'h004, 0, 0, "R6");
        drive(10'h3FB, 0, 0, "R6");
        drive(10'h200, 1, 0, "R6");
        // R4 filter disabled: flag still low for R7
        drive(10'h002, 1, 0, "R4");
        drive(10'h3FD, 1, 0, "R4");
        drive(10'h0AA, 1, 0, "R4");
        // R5 / R9 transport mode
        drive(10'h001, 0, 0, "R7");
        drive(10'h001, 0, 1, "R5 R9");
        drive(10'h3FC, 0, 1, "R5 R9");
        drive(10'h3FE, 1, 1, "R5 R9");
        drive(10'h3FC, 0, 0, "R7");
        drive(10'h2F0, 0, 1, "R5");
        // sweep across the low range with filter toggling
        for (int i = 0; i < 16; i++) begin
            drive(10'(i * 37), i[0], i[3], "R2 R6 sweep");
            drive(10'h3F8 + 10'(i % 8), i[1], 0, "R3 R6 sweep");
        end
        drive(10'h100, 1, 0, "R8");
        repeat (4) @(posedge clk);
        #2;
        finish_run();
    end

endmodule